// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Error Flags

This block recovers characters from an asynchronous serial line. A separate receive clock sets the bit timing. The block samples the line on the rising edges of that clock, counting 1, 16 or 64 edges per bit. It checks the start bit, collects 7 or 8 data bits least significant bit first, checks an optional parity bit, and checks the first stop bit. It then places the character in a one-deep receive data register.

Four flags travel with the held character: receive-full, framing error, parity error and overrun. The framing and parity flags belong to the character in the register. They change only when a new character is loaded. A host-side read strobe acts as the read of the data register. It frees the register. When a character was lost, the first read shows the overrun and the second read clears it. Both the serial line and the receive clock are synchronised into the system clock domain. All outputs come from registers.

Top module: `serial_rx_core`

## Requirements
- R1: After `rst`, `rx_full`, `frame_err`, `parity_err` and `overrun` are all 0, and they stay 0 while the line is idle (high).
- R2: `div_sel` sets how many rising `rx_clk` edges make one bit: 00 gives 1, 01 gives 16, 10 gives 64. Data bits arrive least significant bit first. In the 1 mode, each bit is sampled on a rising receive-clock edge and the start bit is not checked. In the 16 and 64 modes, each bit is sampled at its centre.
- R3: `word_fmt` encodings: 000 is 7 data bits, even parity, 2 stop. 001 is 7, odd, 2 stop. 010 is 7, even, 1 stop. 011 is 7, odd, 1 stop. 100 is 8 data bits, no parity, 2 stop. 101 is 8, none, 1 stop. 110 is 8, even, 1 stop. 111 is 8, odd, 1 stop. In the 7-bit formats, bit 7 of `rx_data` is 0.
- R4: `parity_err` is set when the total count of ones over the data bits and the parity bit disagrees with the selected parity. Even parity expects an even total and odd parity expects an odd total. With no parity selected, `parity_err` is 0.
- R5: `frame_err` is set when the first stop bit is sampled as 0. After such a character, the receiver waits for the line to return high before it looks for a new start bit.
- R6: `frame_err` and `parity_err` change only when a character is loaded into the data register. They stay unchanged while that character is held.
- R7: In the 16 and 64 modes, a start bit is accepted only if the line is still low at its half-bit point. Otherwise the receiver returns to idle and loads nothing.
- R8: A one-cycle `rd_strobe` pulse while `rx_full` is 1 and no overrun is pending clears `rx_full` and `overrun`.
- R9: A character that completes while `rx_full` is 1 is lost, and `rx_data` keeps the earlier character. The loss is detected at the mid-point sample of the lost character's first stop bit. `overrun` stays 0 until the next `rd_strobe`. That strobe sets `overrun` and leaves `rx_full` at 1. A further strobe clears both.
- R10: Reception continues during an overrun. A character that arrives after the overrun has been cleared is received correctly.
- R11: `div_sel` = 11 acts as a master reset. While it is held, `rx_full`, `overrun`, `frame_err` and `parity_err` are 0 from the next cycle on, and any frame in progress is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_clk | input | 1 | Receive bit clock, sampled on its rising edges |
| rx_line | input | 1 | Serial data input, idle high |
| div_sel | input | 2 | Edges per bit: 00 gives 1, 01 gives 16, 10 gives 64; 11 is master reset |
| word_fmt | input | 3 | Character format (see R3) |
| rd_strobe | input | 1 | One-cycle read of the data register |
| rx_data | output | 8 | Held character |
| rx_full | output | 1 | Data register holds an unread character |
| frame_err | output | 1 | Held character had a 0 first stop bit |
| parity_err | output | 1 | Held character failed its parity check |
| overrun | output | 1 | A character was lost (visible after one read) |

## Verification
The assertions check the following on every cycle:
- A pending or visible overrun always coincides with a full register.
- The error flags and the data stay frozen between loads.
- A read of a full register with nothing pending empties it.
- Master reset clears the flags.
- A high line never starts a frame.
- A newly loaded 7-bit character has bit 7 at 0, and a character loaded under a no-parity format has no parity error.

Only the bench scenarios can show the rest:
- Characters are decoded correctly in all eight formats and all three rates.
- A short start glitch is rejected.
- The flags from a bad parity bit or a missing stop bit are correct.
- The two-read order of the overrun, and the correct reception of a character sent after it.

// File: rtl/serrx_pkg.sv
package serrx_pkg;

  typedef enum logic [1:0] {
    DIV_1    = 2'b00,
    DIV_16   = 2'b01,
    DIV_64   = 2'b10,
    DIV_MRST = 2'b11
  } div_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP,
    ST_BRK
  } rx_st_e;

  typedef struct packed {
    logic [7:0] data;
    logic       ferr;
    logic       perr;
  } rx_char_t;

  function automatic logic fmt_eight(input logic [2:0] f);
    return f[2];
  endfunction

  function automatic logic fmt_par_en(input logic [2:0] f);
    return ~f[2] | f[1];
  endfunction

  function automatic logic fmt_odd(input logic [2:0] f);
    return f[0];
  endfunction

endpackage

// File: rtl/serrx_sync.sv
module serrx_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] q;

  always_ff @(posedge clk) begin
    if (rst) q <= {STAGES{RESET_VAL}};
    else     q <= {q[STAGES-2:0], din};
  end

  assign dout = q[STAGES-1];
endmodule

// File: rtl/serrx_tick.sv
module serrx_tick (
  input  logic clk,
  input  logic rst,
  input  logic clk_s,
  input  logic line_s,
  output logic tick,
  output logic line_q
);
  logic prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev   <= 1'b0;
      tick   <= 1'b0;
      line_q <= 1'b1;
    end else begin
      prev   <= clk_s;
      tick   <= clk_s & ~prev;
      line_q <= line_s;
    end
  end
endmodule

// File: rtl/serrx_framer.sv
module serrx_framer
  import serrx_pkg::*;
#(
  parameter int DIV_MID = 16,
  parameter int DIV_HI  = 64
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       abort,
  input  logic       tick,
  input  logic       line,
  input  logic [1:0] div_sel,
  input  logic [2:0] fmt,
  output logic       done,
  output rx_char_t   char_o
);
  localparam int CW = $clog2(DIV_HI);

  rx_st_e        st;
  logic [CW-1:0] cnt, half_lim, full_lim;
  logic [3:0]    bit_idx, last_idx;
  logic [7:0]    sh, aligned;
  logic          pbit, at_sample;

  always_comb begin
    case (div_sel)
      DIV_16: begin
        full_lim = CW'(DIV_MID - 1);
        half_lim = CW'(DIV_MID / 2 - 1);
      end
      DIV_64: begin
        full_lim = CW'(DIV_HI - 1);
        half_lim = CW'(DIV_HI / 2 - 1);
      end
      default: begin
        full_lim = '0;
        half_lim = '0;
      end
    endcase
    last_idx  = fmt_eight(fmt) ? 4'd7 : 4'd6;
    aligned   = fmt_eight(fmt) ? sh : {1'b0, sh[7:1]};
    at_sample = (cnt == full_lim);
  end

  always_ff @(posedge clk) begin
    if (rst || abort) begin
      st      <= ST_IDLE;
      cnt     <= '0;
      bit_idx <= '0;
      sh      <= '0;
      pbit    <= 1'b0;
      done    <= 1'b0;
      char_o  <= '0;
    end else begin
      done <= 1'b0;
      if (tick) begin
        case (st)
          ST_IDLE: if (!line) begin
            cnt     <= '0;
            bit_idx <= '0;
            st      <= (div_sel == DIV_1) ? ST_DATA : ST_START;
          end
          ST_START: begin
            if (cnt == half_lim) begin
              cnt <= '0;
              st  <= line ? ST_IDLE : ST_DATA;
            end else cnt <= cnt + 1'b1;
          end
          ST_DATA: begin
            if (at_sample) begin
              cnt <= '0;
              sh  <= {line, sh[7:1]};
              if (bit_idx == last_idx) begin
                bit_idx <= '0;
                st      <= fmt_par_en(fmt) ? ST_PAR : ST_STOP;
              end else bit_idx <= bit_idx + 1'b1;
            end else cnt <= cnt + 1'b1;
          end
          ST_PAR: begin
            if (at_sample) begin
              cnt  <= '0;
              pbit <= line;
              st   <= ST_STOP;
            end else cnt <= cnt + 1'b1;
          end
          ST_STOP: begin
            if (at_sample) begin
              cnt         <= '0;
              done        <= 1'b1;
              char_o.data <= aligned;
              char_o.ferr <= ~line;
              char_o.perr <= fmt_par_en(fmt) & (^aligned ^ pbit ^ fmt_odd(fmt));
              st          <= line ? ST_IDLE : ST_BRK;
            end else cnt <= cnt + 1'b1;
          end
          ST_BRK: if (line) st <= ST_IDLE;
          default: st <= ST_IDLE;
        endcase
      end
    end
  end

  // R7
  idle_high_stays_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE && tick && line && !abort) |=> st == ST_IDLE);

  // R2
  done_after_stop_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(st) == ST_STOP);
endmodule

// File: rtl/serrx_holding.sv
module serrx_holding
  import serrx_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       mrst,
  input  logic       load,
  input  rx_char_t   ch_in,
  input  logic       rd,
  output logic [7:0] data,
  output logic       full,
  output logic       ferr,
  output logic       perr,
  output logic       ovr
);
  logic pend;
  logic full_n, pend_n, ovr_n, take;

  always_comb begin
    full_n = full;
    pend_n = pend;
    ovr_n  = ovr;
    take   = 1'b0;
    if (rd && full) begin
      if (pend) begin
        ovr_n  = 1'b1;
        pend_n = 1'b0;
      end else begin
        full_n = 1'b0;
        ovr_n  = 1'b0;
      end
    end
    if (load) begin
      if (full_n) begin
        if (!ovr_n) pend_n = 1'b1;
      end else begin
        take   = 1'b1;
        full_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || mrst) begin
      data <= '0;
      full <= 1'b0;
      ferr <= 1'b0;
      perr <= 1'b0;
      ovr  <= 1'b0;
      pend <= 1'b0;
    end else begin
      full <= full_n;
      pend <= pend_n;
      ovr  <= ovr_n;
      if (take) begin
        data <= ch_in.data;
        ferr <= ch_in.ferr;
        perr <= ch_in.perr;
      end
    end
  end

  // R9
  pend_needs_full_chk: assert property (@(posedge clk) disable iff (rst)
    pend |-> full);

  // R9
  ovr_needs_full_chk: assert property (@(posedge clk) disable iff (rst)
    ovr |-> full);

  // R8
  read_empties_chk: assert property (@(posedge clk) disable iff (rst)
    (rd && full && !pend && !load && !mrst) |=> !full && !ovr);

  // R6
  held_char_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    (!load && !mrst) |=> $stable(data) && $stable(ferr) && $stable(perr));

  // R11
  master_reset_clears_chk: assert property (@(posedge clk) disable iff (rst)
    mrst |=> !full && !ovr && !ferr && !perr);
endmodule

// File: rtl/serial_rx_core.sv
module serial_rx_core
  import serrx_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DIV_MID     = 16,
  parameter int DIV_HI      = 64
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       rx_clk,
  input  logic       rx_line,
  input  logic [1:0] div_sel,
  input  logic [2:0] word_fmt,
  input  logic       rd_strobe,
  output logic [7:0] rx_data,
  output logic       rx_full,
  output logic       frame_err,
  output logic       parity_err,
  output logic       overrun
);
  logic     clk_s, line_s, tick, line_q, mrst, done;
  rx_char_t ch;

  assign mrst = (div_sel == DIV_MRST);

  serrx_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_sclk (
    .clk(clk), .rst(rst), .din(rx_clk), .dout(clk_s));

  serrx_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sline (
    .clk(clk), .rst(rst), .din(rx_line), .dout(line_s));

  serrx_tick u_tick (
    .clk(clk), .rst(rst), .clk_s(clk_s), .line_s(line_s),
    .tick(tick), .line_q(line_q));

  serrx_framer #(.DIV_MID(DIV_MID), .DIV_HI(DIV_HI)) u_frm (
    .clk(clk), .rst(rst), .abort(mrst), .tick(tick), .line(line_q),
    .div_sel(div_sel), .fmt(word_fmt), .done(done), .char_o(ch));

  serrx_holding u_hold (
    .clk(clk), .rst(rst), .mrst(mrst), .load(done), .ch_in(ch),
    .rd(rd_strobe), .data(rx_data), .full(rx_full), .ferr(frame_err),
    .perr(parity_err), .ovr(overrun));

  // R3
  seven_bit_top_zero_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(rx_full) && !word_fmt[2]) |-> !rx_data[7]);

  // R4
  no_parity_no_error_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(rx_full) && word_fmt[2:1] == 2'b10) |-> !parity_err);
endmodule

// File: tb/sim_serial_rx_core.sv
`timescale 1ns/1ps
module sim_serial_rx_core;
  logic       clk = 1'b0, rst = 1'b1, rx_clk = 1'b0, rx_line = 1'b1;
  logic [1:0] div_sel = 2'b00;
  logic [2:0] word_fmt = 3'b101;
  logic       rd_strobe = 1'b0;
  logic [7:0] rx_data;
  logic       rx_full, frame_err, parity_err, overrun;
  int nchk = 0, nfail = 0;
  bit done_flag = 1'b0;

  serial_rx_core u0 (
    .clk(clk), .rst(rst), .rx_clk(rx_clk), .rx_line(rx_line),
    .div_sel(div_sel), .word_fmt(word_fmt), .rd_strobe(rd_strobe),
    .rx_data(rx_data), .rx_full(rx_full), .frame_err(frame_err),
    .parity_err(parity_err), .overrun(overrun));

  always #2.5 clk = ~clk;
  always #20 rx_clk = ~rx_clk;

  task automatic check(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [1:0] code_of(input int ratio);
    return (ratio == 1) ? 2'b00 : (ratio == 16) ? 2'b01 : 2'b10;
  endfunction

  task automatic hold_bit(input logic b, input int ratio);
    rx_line = b;
    repeat (ratio) @(negedge rx_clk);
  endtask

  task automatic send_char(input logic [7:0] d, input int ratio,
                           input bit flip_par, input bit bad_stop);
    int  nb;
    logic pb;
    nb = word_fmt[2] ? 8 : 7;
    pb = (word_fmt[2] ? ^d : ^d[6:0]) ^ word_fmt[0] ^ flip_par;
    @(negedge rx_clk);
    hold_bit(1'b0, ratio);
    for (int i = 0; i < nb; i++) hold_bit(d[i], ratio);
    if (!word_fmt[2] || word_fmt[1]) hold_bit(pb, ratio);
    hold_bit(~bad_stop, ratio);
    hold_bit(1'b1, 2 * ratio);
    repeat (8) @(negedge clk);
  endtask

  task automatic do_read;
    @(negedge clk) rd_strobe = 1'b1;
    @(negedge clk) rd_strobe = 1'b0;
    @(negedge clk);
  endtask

  task automatic sweep_char(input logic [7:0] d, input int ratio);
    logic [7:0] e;
    e = word_fmt[2] ? d : {1'b0, d[6:0]};
    send_char(d, ratio, 1'b0, 1'b0);
    check("R2 full after char", rx_full, 1);
    check("R3 data value", rx_data, e);
    check("R4 parity clean", parity_err, 0);
    check("R5 framing clean", frame_err, 0);
    do_read();
    check("R8 read empties", rx_full, 0);
  endtask

  initial begin
    repeat (6) @(negedge clk);
    rst = 1'b0;
    repeat (40) @(negedge clk);
    // R1 reset state
    check("R1 full", rx_full, 0);
    check("R1 ferr", frame_err, 0);
    check("R1 perr", parity_err, 0);
    check("R1 ovr", overrun, 0);

    // R2 R3 R4 sweeps over all formats and rates
    div_sel = code_of(1);
    for (int f = 0; f < 8; f++) begin
      word_fmt = 3'(f);
      for (int k = 0; k < 32; k++) sweep_char(8'((k * 37 + 5) % 256), 1);
    end
    div_sel = code_of(16);
    for (int f = 0; f < 8; f++) begin
      word_fmt = 3'(f);
      sweep_char(8'hA5, 16);
      sweep_char(8'h3C ^ 8'(f), 16);
    end
    div_sel = code_of(64);
    for (int f = 0; f < 8; f++) begin
      word_fmt = 3'(f);
      sweep_char(8'(8'h81 + f * 29), 64);
    end

    // R4 parity error, R6 flags follow the held character
    div_sel = code_of(16);
    word_fmt = 3'b011;
    send_char(8'h55, 16, 1'b1, 1'b0);
    check("R4 parity error set", parity_err, 1);
    check("R5 no framing error", frame_err, 0);
    do_read();
    check("R6 flag kept after read", parity_err, 1);
    send_char(8'h2A, 16, 1'b0, 1'b0);
    check("R6 new char clears perr", parity_err, 0);
    check("R6 new char data", rx_data, 8'h2A);
    do_read();

    // R5 framing error and recovery
    word_fmt = 3'b101;
    send_char(8'hC3, 16, 1'b0, 1'b1);
    check("R5 framing error set", frame_err, 1);
    check("R5 data still loaded", rx_data, 8'hC3);
    do_read();
    send_char(8'h11, 16, 1'b0, 1'b0);
    check("R5 clean after recovery", frame_err, 0);
    check("R5 data after recovery", rx_data, 8'h11);
    do_read();

    // R7 start glitch rejected
    @(negedge rx_clk);
    hold_bit(1'b0, 3);
    hold_bit(1'b1, 40);
    check("R7 glitch ignored", rx_full, 0);
    send_char(8'h7E, 16, 1'b0, 1'b0);
    check("R7 good char after glitch", rx_data, 8'h7E);
    do_read();

    // R9 overrun two-read order, R10 sync kept
    send_char(8'hA1, 16, 1'b0, 1'b0);
    send_char(8'hB2, 16, 1'b0, 1'b0);
    check("R9 full held", rx_full, 1);
    check("R9 overrun hidden", overrun, 0);
    check("R9 earlier data kept", rx_data, 8'hA1);
    do_read();
    check("R9 overrun shown", overrun, 1);
    check("R9 full still set", rx_full, 1);
    check("R9 data unchanged", rx_data, 8'hA1);
    do_read();
    check("R9 overrun cleared", overrun, 0);
    check("R9 full cleared", rx_full, 0);
    send_char(8'hC7, 16, 1'b0, 1'b0);
    check("R10 next char data", rx_data, 8'hC7);
    check("R10 next char full", rx_full, 1);
    do_read();

    // R11 master reset
    send_char(8'h42, 16, 1'b0, 1'b0);
    send_char(8'h43, 16, 1'b0, 1'b0);
    @(negedge clk) div_sel = 2'b11;
    repeat (3) @(negedge clk);
    check("R11 full cleared", rx_full, 0);
    check("R11 overrun cleared", overrun, 0);
    div_sel = code_of(16);
    repeat (20) @(negedge clk);
    send_char(8'h99, 16, 1'b0, 1'b0);
    check("R11 receive after reset", rx_data, 8'h99);
    check("R11 full after reset", rx_full, 1);

    done_flag = 1'b1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done_flag) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end
endmodule